// File: doc/BRIEF.md
# Branch condition and target unit

This block works out where a jump sends the program counter. It receives the program counter already pointing at the next instruction, a 3-bit code for the kind of jump, an 8-bit displacement, a 16-bit absolute target, and a register operand. It reads four ALU condition flags and four serial transceiver status flags. It returns a taken flag and the next program counter value, and it does so in the same cycle.

Relative jumps add a sign-extended byte to the program counter. The byte comes either from the instruction or from the low byte of the register operand. Absolute jumps load a full 16-bit address, either from the instruction or from the register operand used as an index. Two kinds are conditional. One tests a selected flag against a wanted state and then jumps relative. The other tests any bit of the register operand against a wanted state and then jumps absolute. Mnemonic condition forms, such as not-zero as Z=0 or positive as N=0, are resolved by the decoder into a selector and state pair before they reach this block.

Top module: `bcu_branch_unit`

## Requirements
- R1: With kind 0 (relative immediate), taken_o is 1 and pc_next_o equals pc_i plus disp_i sign-extended to 16 bits, modulo 2^16.
- R2: With kind 1 (relative register), taken_o is 1 and pc_next_o equals pc_i plus reg_i[7:0] sign-extended, modulo 2^16. disp_i has no effect on the result.
- R3: With kind 2 (absolute immediate), taken_o is 1 and pc_next_o equals target_i.
- R4: With kind 3 (indexed absolute), taken_o is 1 and pc_next_o equals reg_i.
- R5: The flag selector picks one flag. The ALU flags are alu_flags_i bit 0 Z, bit 1 C, bit 2 V and bit 3 N, at selector codes 0 to 3. The transceiver flags are xcvr_flags_i bit 0 receiver active, bit 1 receiver error, bit 2 data available and bit 3 transmit FIFO full, at selector codes 4 to 7.
- R6: With kind 4 (conditional relative), taken_o is 1 exactly when the selected flag equals flag_state_i. When taken, pc_next_o is pc_i plus disp_i sign-extended. Otherwise pc_next_o equals pc_i.
- R7: With kind 5 (conditional bit-test absolute), taken_o is 1 exactly when reg_i[bit_pos_i] equals bit_state_i. When taken, pc_next_o equals target_i. Otherwise pc_next_o equals pc_i.
- R8: Kinds 6 and 7 are reserved. They give taken_o 0 and pc_next_o equal to pc_i.
- R9: Relative sums wrap modulo 2^16. For example, 0xFFFF plus 1 gives 0x0000, and 0x0000 plus -128 gives 0xFF80.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pc_i | input | 16 | Address of the instruction after the jump |
| kind_i | input | 3 | Jump kind code |
| disp_i | input | 8 | Signed displacement from the instruction |
| target_i | input | 16 | Absolute target from the instruction |
| flag_sel_i | input | 3 | Flag selector |
| flag_state_i | input | 1 | Wanted state of the selected flag |
| reg_i | input | 16 | Register operand (byte source, index or bit-test value) |
| bit_pos_i | input | 4 | Bit position tested in reg_i |
| bit_state_i | input | 1 | Wanted state of the tested bit |
| alu_flags_i | input | 4 | ALU flags {N,V,C,Z} |
| xcvr_flags_i | input | 4 | Transceiver flags {TX full, data avail, RX error, RX active} |
| taken_o | output | 1 | Jump is taken |
| pc_next_o | output | 16 | Next program counter |

## Verification
The hardest case to reach is a conditional jump whose flag selector is in range but where every other flag holds the opposite value. Only in that case does a wrong selector index show up as a wrong taken result. The directed part of the stimulus loops over all eight selectors and both wanted states. For each pair it drives the selected flag to each value while the other seven flags are set to the complement. Random vectors then mix all kinds, including the reserved codes, and sweep the program counter through both ends of the address space to exercise wraparound.

// File: rtl/bcu_pkg.sv
package bcu_pkg;
  typedef enum logic [2:0] {
    JK_REL_IMM  = 3'd0,
    JK_REL_REG  = 3'd1,
    JK_ABS_IMM  = 3'd2,
    JK_ABS_IDX  = 3'd3,
    JK_COND_REL = 3'd4,
    JK_COND_BIT = 3'd5,
    JK_RSVD6    = 3'd6,
    JK_RSVD7    = 3'd7
  } jump_kind_e;

  localparam int unsigned NUM_ALU_FLAGS  = 4;
  localparam int unsigned NUM_XCVR_FLAGS = 4;
  localparam int unsigned NUM_FLAGS      = NUM_ALU_FLAGS + NUM_XCVR_FLAGS;
  localparam int unsigned FSEL_W         = $clog2(NUM_FLAGS);
endpackage

// File: rtl/bcu_cond_eval.sv
module bcu_cond_eval
  import bcu_pkg::*;
#(
  parameter int unsigned REG_W = 16,
  localparam int unsigned POS_W = $clog2(REG_W)
) (
  input  logic [NUM_ALU_FLAGS-1:0]  alu_flags_i,
  input  logic [NUM_XCVR_FLAGS-1:0] xcvr_flags_i,
  input  logic [FSEL_W-1:0]         flag_sel_i,
  input  logic                      flag_state_i,
  input  logic [REG_W-1:0]          reg_i,
  input  logic [POS_W-1:0]          bit_pos_i,
  input  logic                      bit_state_i,
  output logic                      flag_hit_o,
  output logic                      bit_hit_o
);
  logic [NUM_FLAGS-1:0] flag_vec;

  // ALU flags occupy the low selector codes, transceiver flags the high ones
  for (genvar g = 0; g < NUM_FLAGS; g++) begin : g_flag
    if (g < NUM_ALU_FLAGS) begin : g_alu
      assign flag_vec[g] = alu_flags_i[g];
    end else begin : g_xcvr
      assign flag_vec[g] = xcvr_flags_i[g-NUM_ALU_FLAGS];
    end
  end

  assign flag_hit_o = (flag_vec[flag_sel_i] == flag_state_i);
  assign bit_hit_o  = (reg_i[bit_pos_i] == bit_state_i);
endmodule

// File: rtl/bcu_target_gen.sv
module bcu_target_gen #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8
) (
  input  logic [PC_W-1:0]   pc_i,
  input  logic [DISP_W-1:0] disp_i,
  input  logic [PC_W-1:0]   target_i,
  input  logic [PC_W-1:0]   reg_i,
  input  logic              disp_from_reg_i,
  input  logic              abs_from_reg_i,
  output logic [PC_W-1:0]   rel_tgt_o,
  output logic [PC_W-1:0]   abs_tgt_o
);
  localparam int unsigned EXT_W = PC_W - DISP_W;

  logic [DISP_W-1:0] disp;
  logic [PC_W-1:0]   disp_ext;

  assign disp      = disp_from_reg_i ? reg_i[DISP_W-1:0] : disp_i;
  assign disp_ext  = {{EXT_W{disp[DISP_W-1]}}, disp};
  assign rel_tgt_o = pc_i + disp_ext;  // modular wrap intended
  assign abs_tgt_o = abs_from_reg_i ? reg_i : target_i;
endmodule

// File: rtl/bcu_branch_unit.sv
module bcu_branch_unit
  import bcu_pkg::*;
#(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8,
  localparam int unsigned POS_W = $clog2(PC_W)
) (
  input  logic [PC_W-1:0]           pc_i,
  input  logic [2:0]                kind_i,
  input  logic [DISP_W-1:0]         disp_i,
  input  logic [PC_W-1:0]           target_i,
  input  logic [FSEL_W-1:0]         flag_sel_i,
  input  logic                      flag_state_i,
  input  logic [PC_W-1:0]           reg_i,
  input  logic [POS_W-1:0]          bit_pos_i,
  input  logic                      bit_state_i,
  input  logic [NUM_ALU_FLAGS-1:0]  alu_flags_i,
  input  logic [NUM_XCVR_FLAGS-1:0] xcvr_flags_i,
  output logic                      taken_o,
  output logic [PC_W-1:0]           pc_next_o
);
  jump_kind_e      kind;
  logic            flag_hit, bit_hit;
  logic [PC_W-1:0] rel_tgt, abs_tgt;

  assign kind = jump_kind_e'(kind_i);

  bcu_cond_eval #(.REG_W(PC_W)) u_cond (
    .alu_flags_i  (alu_flags_i),
    .xcvr_flags_i (xcvr_flags_i),
    .flag_sel_i   (flag_sel_i),
    .flag_state_i (flag_state_i),
    .reg_i        (reg_i),
    .bit_pos_i    (bit_pos_i),
    .bit_state_i  (bit_state_i),
    .flag_hit_o   (flag_hit),
    .bit_hit_o    (bit_hit)
  );

  bcu_target_gen #(.PC_W(PC_W), .DISP_W(DISP_W)) u_tgt (
    .pc_i            (pc_i),
    .disp_i          (disp_i),
    .target_i        (target_i),
    .reg_i           (reg_i),
    .disp_from_reg_i (kind == JK_REL_REG),
    .abs_from_reg_i  (kind == JK_ABS_IDX),
    .rel_tgt_o       (rel_tgt),
    .abs_tgt_o       (abs_tgt)
  );

  always_comb begin
    taken_o = 1'b0;
    unique case (kind)
      JK_REL_IMM, JK_REL_REG, JK_ABS_IMM, JK_ABS_IDX: taken_o = 1'b1;
      JK_COND_REL: taken_o = flag_hit;
      JK_COND_BIT: taken_o = bit_hit;
      default:     taken_o = 1'b0;
    endcase
  end

  always_comb begin
    pc_next_o = pc_i;
    if (taken_o) begin
      unique case (kind)
        JK_REL_IMM, JK_REL_REG, JK_COND_REL: pc_next_o = rel_tgt;
        default:                             pc_next_o = abs_tgt;
      endcase
    end
  end
endmodule

// File: rtl/bcu_branch_unit_chk.sv
module bcu_branch_unit_chk #(
  parameter int unsigned PC_W   = 16,
  parameter int unsigned DISP_W = 8
) (
  input logic [PC_W-1:0] pc_i,
  input logic [2:0]      kind_i,
  input logic [PC_W-1:0] target_i,
  input logic [PC_W-1:0] reg_i,
  input logic            taken_o,
  input logic [PC_W-1:0] pc_next_o
);
  always_comb begin
    if (kind_i <= 3'd3) begin
      a_r1_uncond_taken: assert (taken_o);
    end
    if (kind_i == 3'd2) begin
      a_r3_abs_load: assert (pc_next_o == target_i);
    end
    if (kind_i == 3'd3) begin
      a_r4_idx_load: assert (pc_next_o == reg_i);
    end
    if ((kind_i == 3'd4 || kind_i == 3'd5) && !taken_o) begin
      a_r6_hold_pc: assert (pc_next_o == pc_i);
    end
    if (kind_i == 3'd5 && taken_o) begin
      a_r7_bit_target: assert (pc_next_o == target_i);
    end
    if (kind_i[2:1] == 2'b11) begin
      a_r8_reserved: assert (!taken_o && pc_next_o == pc_i);
    end
  end
endmodule

bind bcu_branch_unit bcu_branch_unit_chk #(.PC_W(PC_W), .DISP_W(DISP_W)) u_chk (.*);

// File: tb/tb_bcu_branch_unit.sv
module tb_bcu_branch_unit;
  logic clk = 1'b0;
  always #4 clk = ~clk;

  logic [15:0] pc, target, regv, pc_next;
  logic [2:0]  kind, fsel;
  logic [7:0]  disp;
  logic        fstate, bstate, taken;
  logic [3:0]  bpos, alu, xcvr;

  int n_chk = 0, n_fail = 0;

  bcu_branch_unit dut (
    .pc_i(pc), .kind_i(kind), .disp_i(disp), .target_i(target),
    .flag_sel_i(fsel), .flag_state_i(fstate), .reg_i(regv),
    .bit_pos_i(bpos), .bit_state_i(bstate), .alu_flags_i(alu),
    .xcvr_flags_i(xcvr), .taken_o(taken), .pc_next_o(pc_next)
  );

  function automatic logic [15:0] rel(input logic [15:0] p, input logic [7:0] d);
    return p + {{8{d[7]}}, d};
  endfunction

  function automatic logic exp_taken();
    logic [7:0] fv;
    fv = {xcvr, alu};
    case (kind)
      3'd0, 3'd1, 3'd2, 3'd3: return 1'b1;
      3'd4: return fv[fsel] == fstate;
      3'd5: return regv[bpos] == bstate;
      default: return 1'b0;
    endcase
  endfunction

  function automatic logic [15:0] exp_pc();
    if (!exp_taken()) return pc;
    case (kind)
      3'd0, 3'd4: return rel(pc, disp);
      3'd1: return rel(pc, regv[7:0]);
      3'd3: return regv;
      default: return target;
    endcase
  endfunction

  function automatic string req_of(input logic [2:0] k);
    case (k)
      3'd0: return "R1";
      3'd1: return "R2";
      3'd2: return "R3";
      3'd3: return "R4";
      3'd4: return "R5/R6";
      3'd5: return "R7";
      default: return "R8";
    endcase
  endfunction

  task automatic check(input string req);
    logic et;
    logic [15:0] ep;
    @(negedge clk);
    et = exp_taken();
    ep = exp_pc();
    n_chk++;
    if (taken !== et) begin
      n_fail++;
      $display("FAIL %s taken act=%0b exp=%0b kind=%0d", req, taken, et, kind);
    end
    n_chk++;
    if (pc_next !== ep) begin
      n_fail++;
      $display("FAIL %s pc_next act=%h exp=%h kind=%0d", req, pc_next, ep, kind);
    end
  endtask

  task automatic drive_rand();
    pc = 16'($urandom); target = 16'($urandom); regv = 16'($urandom);
    disp = 8'($urandom); kind = 3'($urandom); fsel = 3'($urandom);
    fstate = 1'($urandom); bstate = 1'($urandom); bpos = 4'($urandom);
    alu = 4'($urandom); xcvr = 4'($urandom);
  endtask

  initial begin
    void'($urandom(32'd2718));
    pc = '0; target = '0; regv = '0; disp = '0; kind = '0; fsel = '0;
    fstate = 0; bstate = 0; bpos = '0; alu = '0; xcvr = '0;
    check("R1 idle");
    // R1, R9: wraparound at both ends
    kind = 3'd0; pc = 16'hFFFF; disp = 8'h01; check("R9 wrap up");
    pc = 16'h0000; disp = 8'h80; check("R9 wrap down");
    pc = 16'h1000; disp = 8'h7F; check("R1 max disp");
    // R2: register byte, instruction disp ignored
    kind = 3'd1; pc = 16'hFFF0; regv = 16'hAB20; disp = 8'h80; check("R2");
    kind = 3'd2; target = 16'hFFFF; check("R3");
    kind = 3'd3; regv = 16'h0000; target = 16'h1234; check("R4");
    // R5, R6: all selector/state pairs, other flags opposite
    kind = 3'd4; pc = 16'h4000; disp = 8'hF0;
    for (int s = 0; s < 8; s++) begin
      for (int st = 0; st < 2; st++) begin
        for (int fv = 0; fv < 2; fv++) begin
          logic [7:0] v;
          fsel = 3'(s); fstate = 1'(st);
          v = fv[0] ? ~(8'h1 << s) : (8'h1 << s);
          v = fv[0] ? ~v : v;
          v = fv[0] ? v : ~v;
          v[s] = fv[0];
          {xcvr, alu} = v;
          check("R5/R6 flag combo");
        end
      end
    end
    // R7: bit test, both outcomes at edge positions
    kind = 3'd5; target = 16'hBEEF; pc = 16'h0102;
    regv = 16'h8001; bpos = 4'd15; bstate = 1'b1; check("R7 hit");
    bstate = 1'b0; check("R7 miss");
    bpos = 4'd1; check("R7 hit low");
    // R8: reserved kinds
    kind = 3'd6; check("R8 k6");
    kind = 3'd7; check("R8 k7");
    for (int i = 0; i < 3000; i++) begin
      drive_rand();
      if (i % 4 == 0) pc = (i % 8 == 0) ? 16'hFFFF - 16'($urandom_range(0, 3)) : 16'($urandom_range(0, 3));
      check(req_of(kind));
    end
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=timeout exp=done");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule